// File: doc/BRIEF.md
# Single-Bit Quadrature Channelizer

This block turns a one-bit oversampled stream, as produced by a delta or delta-sigma modulator, into baseband in-phase and quadrature words at a reduced rate. Each accepted input bit is mixed with two one-bit square-wave local oscillators that sit a quarter period apart. The two oscillators come from a chain of toggle flip-flops that advances once per accepted sample. Each product path then goes through a second-order cascaded integrator-comb decimator. The integrators run on every accepted sample. A downsampler keeps one integrator value in every R. The two comb differentiators run only on those kept values.

The decimation ratio is a power of two, picked by a 3-bit exponent. A new ratio is loaded only by a synchronous clear, which also empties all filter and oscillator state. The input side is a valid-qualified stream with no back-pressure: every cycle with `in_valid` high and `clear` low consumes one bit. The output side is a one-cycle `out_valid` strobe with no ready, so the consumer must take each I/Q pair on the cycle it is flagged. The words then hold until the next pair.

Top module: `quad_channelizer`

## Requirements
- R1: After reset, or on the cycle after a clear, `out_valid` is 0 and `out_i` and `out_q` are 0. A sample presented in the same cycle as `clear` is discarded.
- R2: Accepted samples after a clear carry a phase p that runs 0,1,2,3,0,... With the default two-stage divider, the I oscillator bit is 0,0,1,1 for p = 0..3 and the Q oscillator bit is 0,1,1,0.
- R3: Each path forms a signed mix value of +1 when the input bit equals that path's oscillator bit, and -1 when they differ.
- R4: Let A(N) be the double running sum over the first N accepted samples since clear: the first sum includes samples 0..k-1, and the second sum adds the first sum for k = 0..N-1. The n-th output of a path (n ≥ 3) is A(nR) − 2·A((n−1)R) + A((n−2)R), with A(0) = 0.
- R5: `out_valid` is high for exactly one cycle. It rises on the clock edge after the edge that accepted sample nR−1, so that pair n appears every R accepted samples.
- R6: The pairs for n = 1 and n = 2 after a clear are not flagged. The first flagged pair is n = 3.
- R7: Cycles with `in_valid` low do not advance the oscillator, the integrators or the decimation count. `out_valid` is only ever high two edges after an accepted sample.
- R8: R = 16·2^`dec_exp`, giving 16 to 2048. The exponent is sampled only on a clear cycle, and R is 16 after reset. A change of `dec_exp` without a clear has no effect.
- R9: Integrators and combs are 24 bits wide (2 + 2·log2 of the largest R) and wrap in two's complement, so outputs stay exact modulo 2^24 even after the integrators overflow.
- R10: `out_i` and `out_q` change only on a cycle with `out_valid` high, or on the cycle after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all state; loads `dec_exp` |
| dec_exp | input | 3 | Decimation exponent, R = 16·2^dec_exp |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | One-bit modulator sample |
| out_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| out_i | output | 24 | In-phase word, two's complement |
| out_q | output | 24 | Quadrature word, two's complement |

## Verification
The assertions take for granted that `clear` and `in_valid` are known from the first edge after reset. They also assume that `dec_exp` is only meaningful on clear cycles. They do not model the window of R samples, so they rely on R being at least 16, which keeps strobes far apart. The stimulus drives every input away from the clock edge. It issues clears only between decimation boundaries, except for one deliberate clear that drops a sample. It sweeps all eight exponents, which keeps each run well inside these limits.

// File: rtl/qch_pkg.sv
package qch_pkg;

  typedef struct packed {
    logic lo_i;
    logic lo_q;
  } lo_pair_t;

  // Signed product of a one-bit sample and a one-bit oscillator, each read as +/-1
  function automatic logic signed [1:0] mix_sign(input logic d, input logic lo);
    return (d == lo) ? 2'sd1 : -2'sd1;
  endfunction

endpackage

// File: rtl/qch_lo_gen.sv
module qch_lo_gen
  import qch_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     adv,
  output lo_pair_t lo
);
  logic [STAGES-1:0] t;
  logic [STAGES:0]   carry;

  assign carry[0] = adv;

  for (genvar k = 0; k < STAGES; k++) begin : g_tff
    logic tq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tq <= 1'b0;
      else if (clear)    tq <= 1'b0;
      else if (carry[k]) tq <= ~tq;
    end
    assign t[k]       = tq;
    assign carry[k+1] = carry[k] & tq;
  end

  assign lo.lo_i = t[STAGES-1];
  assign lo.lo_q = t[STAGES-1] ^ t[STAGES-2];
endmodule

// File: rtl/qch_integ.sv
module qch_integ #(
  parameter int W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  input  logic signed [1:0] m,
  output logic [W-1:0]      acc2
);
  logic [W-1:0] acc1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1 <= '0;
      acc2 <= '0;
    end else if (clear) begin
      acc1 <= '0;
      acc2 <= '0;
    end else if (adv) begin
      acc1 <= acc1 + {{(W-2){m[1]}}, m};
      acc2 <= acc2 + acc1;
    end
  end
endmodule

// File: rtl/qch_comb.sv
module qch_comb #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         take,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] d1, d2, c1;

  assign c1 = x - d1;
  assign y  = c1 - d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '0;
      d2 <= '0;
    end else if (clear) begin
      d1 <= '0;
      d2 <= '0;
    end else if (take) begin
      d1 <= x;
      d2 <= c1;
    end
  end
endmodule

// File: rtl/quad_channelizer.sv
module quad_channelizer
  import qch_pkg::*;
#(
  parameter int LO_STAGES  = 2,
  parameter int EXP_BITS   = 3,
  parameter int R_MIN_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic [EXP_BITS-1:0] dec_exp,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic                out_valid,
  output logic [2+2*(R_MIN_LOG2+(1<<EXP_BITS)-1)-1:0] out_i,
  output logic [2+2*(R_MIN_LOG2+(1<<EXP_BITS)-1)-1:0] out_q
);
  localparam int R_MAX_LOG2 = R_MIN_LOG2 + (1 << EXP_BITS) - 1;
  localparam int W          = 2 + 2 * R_MAX_LOG2;
  localparam int CW         = R_MAX_LOG2;

  logic [EXP_BITS-1:0] dec_act;
  logic [CW:0]         r_len;
  logic [CW-1:0]       last_idx, cnt;
  logic                adv, bnd, strobe, emit;
  logic [1:0]          fill;
  lo_pair_t            lo;
  logic [1:0][W-1:0]   y_path;

  assign adv      = in_valid & ~clear;
  assign r_len    = {{CW{1'b0}}, 1'b1} << (CW'(R_MIN_LOG2) + CW'(dec_act));
  assign last_idx = r_len[CW-1:0] - CW'(1);
  assign bnd      = adv && (cnt == last_idx);
  assign emit     = strobe && (fill == 2'd2);

  // Ratio exponent is loaded only by clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dec_act <= '0;
    else if (clear) dec_act <= dec_exp;
  end

  // Downsampler: count accepted samples, flag the block boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
      fill   <= '0;
    end else if (clear) begin
      cnt    <= '0;
      strobe <= 1'b0;
      fill   <= '0;
    end else begin
      strobe <= bnd;
      if (adv) cnt <= bnd ? '0 : cnt + CW'(1);
      if (strobe && fill != 2'd2) fill <= fill + 2'd1;
    end
  end

  qch_lo_gen #(.STAGES(LO_STAGES)) u_lo (
    .clk(clk), .rst_n(rst_n), .clear(clear), .adv(adv), .lo(lo)
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic              lo_bit;
    logic signed [1:0] m;
    logic [W-1:0]      acc;
    logic [W-1:0]      y;

    assign lo_bit = (p == 0) ? lo.lo_i : lo.lo_q;
    assign m      = mix_sign(in_bit, lo_bit);

    qch_integ #(.W(W)) u_int (
      .clk(clk), .rst_n(rst_n), .clear(clear), .adv(adv), .m(m), .acc2(acc)
    );
    qch_comb #(.W(W)) u_comb (
      .clk(clk), .rst_n(rst_n), .clear(clear), .take(strobe), .x(acc), .y(y)
    );
    assign y_path[p] = y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (clear) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_i <= y_path[0];
        out_q <= y_path[1];
      end
    end
  end
endmodule

// File: rtl/qch_chk.sv
module qch_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_i,
  input logic [W-1:0] out_q
);
  // R1: clear empties the output side
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && out_i == '0 && out_q == '0));

  // R5: the strobe lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: a strobe needs an accepted sample two edges earlier and no clear since
  a_r7_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid, 2) && !$past(clear, 2) && !$past(clear)));

  // R10: words hold while no strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !$past(clear)) |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind quad_channelizer qch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_quad_channelizer.sv
`timescale 1ns/1ps
module sim_quad_channelizer;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic [2:0]   dec_exp = 3'd0;
  logic         in_valid = 1'b0;
  logic         in_bit = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_i, out_q;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  int       ph, cnt, rlen, nblk;
  int       s1 [2];
  int       acc[2];
  int       h0 [2];
  int       h1 [2];
  int       h2 [2];
  bit       sched;
  logic [W-1:0] nxt_i, nxt_q, exp_i, exp_q;
  logic [15:0]  lf = 16'hACE1;

  always #2.5 clk = ~clk;

  quad_channelizer u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .dec_exp(dec_exp),
    .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model_clear();
    ph = 0; cnt = 0; nblk = 0; sched = 0;
    rlen = 16 << dec_exp;
    for (int p = 0; p < 2; p++) begin
      s1[p] = 0; acc[p] = 0; h0[p] = 0; h1[p] = 0; h2[p] = 0;
    end
  endtask

  // mode: 0 constant val, 1 follow I oscillator, 2 follow Q oscillator, 3 pseudo-random
  task automatic cyc(input bit v, input int mode, input bit val, input bit clr, input string tag);
    bit d, loi, loq, due;
    int m [2];
    int y;
    @(negedge clk);
    loi = (ph >= 2);              // R2 phase pattern 0,0,1,1
    loq = (ph == 1 || ph == 2);   // R2 phase pattern 0,1,1,0
    lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    case (mode)
      0: d = val;
      1: d = loi;
      2: d = loq;
      default: d = lf[0];
    endcase
    in_valid = v; in_bit = d; clear = clr;
    due = sched; sched = 0;
    if (clr) begin
      model_clear(); due = 0; exp_i = '0; exp_q = '0;
    end else if (v) begin
      m[0] = (d == loi) ? 1 : -1;   // R3 mix sign
      m[1] = (d == loq) ? 1 : -1;
      for (int p = 0; p < 2; p++) begin
        acc[p] = acc[p] + s1[p];
        s1[p]  = s1[p] + m[p];
      end
      ph = (ph + 1) % 4;
      cnt++;
      if (cnt == rlen) begin
        cnt = 0; nblk++;
        for (int p = 0; p < 2; p++) begin
          h2[p] = h1[p]; h1[p] = h0[p]; h0[p] = acc[p];
        end
        if (nblk >= 3) begin       // R6 first two blocks silent
          sched = 1;
          y = h0[0] - 2*h1[0] + h2[0]; nxt_i = y[W-1:0];
          y = h0[1] - 2*h1[1] + h2[1]; nxt_q = y[W-1:0];
        end
      end
    end
    if (due) begin exp_i = nxt_i; exp_q = nxt_q; end
    @(posedge clk); #1;
    check(out_valid == due, {"R5 strobe ", tag}, out_valid, due);
    check(out_i == exp_i, {due ? "R4 I " : (clr ? "R1 I " : "R10 I "), tag}, out_i, exp_i);
    check(out_q == exp_q, {due ? "R4 Q " : (clr ? "R1 Q " : "R10 Q "), tag}, out_q, exp_q);
  endtask

  task automatic run(input int n, input bit v, input int mode, input bit val, input string tag);
    for (int k = 0; k < n; k++) cyc(v, mode, val, 1'b0, tag);
  endtask

  initial begin
    model_clear(); exp_i = '0; exp_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R1 reset strobe", out_valid, 0);
    check(out_i == '0, "R1 reset I", out_i, 0);
    check(out_q == '0, "R1 reset Q", out_q, 0);

    // clear with a sample present: sample dropped (R1), R = 16 (R8)
    dec_exp = 3'd0;
    cyc(1'b1, 0, 1'b1, 1'b1, "R1 clear");
    run(200, 1'b1, 0, 1'b1, "R3 ones");
    run(200, 1'b1, 0, 1'b0, "R3 zeros");
    // I path sees +1 forever; long run wraps the 24-bit integrators (R9, R2)
    run(8000, 1'b1, 1, 1'b0, "R2 R9 follow-I");
    run(300, 1'b1, 2, 1'b0, "R2 follow-Q");
    // random gaps in in_valid must not advance anything (R7)
    for (int k = 0; k < 2000; k++) cyc(lf[3] | lf[7], 3, 1'b0, 1'b0, "R7 gaps");
    run(100, 1'b0, 3, 1'b0, "R7 idle");
    // exponent changed without clear is ignored (R8)
    dec_exp = 3'd3;
    run(400, 1'b1, 3, 1'b0, "R8 no-clear");
    // sweep every ratio exponent through a clear
    for (int e = 0; e < 8; e++) begin
      dec_exp = 3'(e);
      cyc(1'b0, 3, 1'b0, 1'b1, "R8 clear");
      run((4 << e) * 16 + 4, 1'b1, 3, 1'b0, "R4 R8 sweep");
    end
    dec_exp = 3'd1;
    cyc(1'b0, 3, 1'b0, 1'b1, "R1 late clear");
    run(150, 1'b1, 1, 1'b0, "R6 refill");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule